// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block generates the bit-level timing of a CAN controller. A programmable prescaler turns the system clock into a time-quantum tick. Each bit is counted as a one-quantum sync segment, then phase segment 1, then phase segment 2. The unit pulses a sample strobe at the end of phase segment 1, together with the line value taken there. It pulses a bit-start strobe whenever a new bit begins.

The received line first passes through a synchronizer. It is then observed on every quantum tick. When the unit sees a recessive-to-dominant transition, it works out how far that edge sits from the expected bit boundary. It then stretches phase segment 1 or trims phase segment 2, never by more than the programmed jump width.

All timing fields arrive on one packed input. They are captured only while reset is asserted, so a bus of changing configuration cannot disturb a bit in progress.

Top module: `can_bit_timing`

## Requirements
- R1: `timing_cfg` is captured on every clock edge where `rst` is high, and is ignored at all other times. Its layout is: bits [5:0] divider field D, bits [9:6] phase-1 field A, bits [12:10] phase-2 field B, bits [14:13] jump field J.
- R2: One time quantum lasts PSC = D + 2 clock cycles.
- R3: With no resynchronization, consecutive `bit_start` pulses are (1 + T1 + T2) × PSC cycles apart, where T1 = A + 1 and T2 = B + 1.
- R4: `sample_stb` pulses for one cycle (1 + T1 + X) × PSC cycles after `bit_start`, where X is the phase-1 extension of R7. `rx_bit` then holds the synchronized line value seen at that quantum tick.
- R5: Directly after reset, `bit_start` and `sample_stb` are 0 and `rx_bit` is 1. The first `bit_start` appears PSC cycles after the first clock edge with `rst` low.
- R6: A falling edge is recognised on a quantum tick where the synchronized line is 0 and was 1 at the previous tick. The edge belongs to the quantum that this tick ends. An edge in the sync quantum leaves the bit length unchanged.
- R7: An edge in the k-th quantum of phase segment 1 (k = 1..T1) lengthens that segment, and the bit, by min(k, SJW) quanta, where SJW = J + 1. This holds even when k = T1 and the sample point would otherwise fall on that tick.
- R8: An edge in the k-th quantum of phase segment 2 (k = 1..T2) shortens the bit by min(T2 − k, SJW) quanta. Phase segment 2 never drops below the quanta already spent in it.
- R9: Dominant-to-recessive transitions never change the bit length.
- R10: Only the first recognised edge of a bit is acted on. Later falling edges in the same bit have no effect.
- R11: `bit_start` and `sample_stb` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also the configuration capture window |
| can_rx | input | 1 | Received bus line (1 = recessive, 0 = dominant) |
| timing_cfg | input | 15 | Packed divider, phase-1, phase-2 and jump fields |
| bit_start | output | 1 | One-cycle pulse at the start of each bit |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| rx_bit | output | 1 | Line value taken at the latest sample point |

## Verification
Two functions can fall on the same quantum tick. The first case is a resynchronizing edge on the tick that would end phase segment 1: the unit must lengthen the segment instead of sampling. The second case is an edge on the final quantum of phase segment 2: the bit must close normally, with zero correction. The bench provokes both by making the line fall exactly three cycles before the targeted tick. It then judges the outcome from the spacing of the next `bit_start` and `sample_stb` pulses and from the sampled value, compared with lengths derived from the requirements.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int PRESC_W = 6;
    localparam int SEG1_W  = 4;
    localparam int SEG2_W  = 3;
    localparam int SJW_W   = 2;
    localparam int CFG_W   = PRESC_W + SEG1_W + SEG2_W + SJW_W;

    // quantum counter covers the longest phase 1 plus the largest extension
    localparam int CNT_W   = SEG1_W + 1;
    localparam int ARITH_W = CNT_W + 1;
    localparam int JW      = SJW_W + 1;

    typedef struct packed {
        logic [SJW_W-1:0]   jump;
        logic [SEG2_W-1:0]  ph2;
        logic [SEG1_W-1:0]  ph1;
        logic [PRESC_W-1:0] div;
    } bt_cfg_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    // limit a phase error to the jump width
    function automatic logic [JW-1:0] clamp_jump(input logic [ARITH_W-1:0] err,
                                                 input logic [JW-1:0] lim);
        if (err > ARITH_W'(lim))
            return lim;
        else
            return err[JW-1:0];
    endfunction

endpackage

// File: rtl/can_tq_div.sv
module can_tq_div
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] div_sel,
    output logic               tq_tick
);
    localparam int DCNT_W = PRESC_W + 1;

    logic [DCNT_W-1:0] cnt_q;
    logic [DCNT_W-1:0] last_val;

    assign last_val = DCNT_W'(div_sel) + DCNT_W'(1);
    assign tq_tick  = (cnt_q == last_val);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tq_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DCNT_W'(1);
    end

    // divider of at least two: ticks never come back to back
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tq_tick |=> !tq_tick);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_val);

endmodule

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '1;
        else
            sh_q <= {sh_q[STAGES-2:0], rx_in};
    end

    assign rx_s = sh_q[STAGES-1];

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bt_cfg_t cfg,
    input  logic    tq_tick,
    input  logic    rx_s,
    output logic    bit_start,
    output logic    sample_stb,
    output logic    rx_bit
);
    seg_e             seg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [JW-1:0]    ext_q;
    logic [JW-1:0]    cut_q;
    logic             done_q;
    logic             rx_tq;

    logic [ARITH_W-1:0] ph1_len, ph2_len, cnt_p1, early_err;
    logic [JW-1:0]      jump_len, ext_now, cut_now;
    logic               fall, ph1_end, ph2_end;

    always_comb begin
        ph1_len   = ARITH_W'(cfg.ph1) + ARITH_W'(1);
        ph2_len   = ARITH_W'(cfg.ph2) + ARITH_W'(1);
        jump_len  = JW'(cfg.jump) + JW'(1);
        cnt_p1    = ARITH_W'(cnt_q) + ARITH_W'(1);
        fall      = tq_tick && rx_tq && !rx_s && !done_q;
        // quanta of phase 2 still left after the current one
        early_err = (cnt_p1 >= ph2_len) ? '0 : (ph2_len - cnt_p1);
        ext_now   = (fall && seg_q == SEG_PH1) ? clamp_jump(cnt_p1, jump_len) : ext_q;
        cut_now   = (fall && seg_q == SEG_PH2) ? clamp_jump(early_err, jump_len) : cut_q;
        ph1_end   = cnt_p1 >= (ph1_len + ARITH_W'(ext_now));
        ph2_end   = (cnt_p1 + ARITH_W'(cut_now)) >= ph2_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q      <= SEG_PH2;
            cnt_q      <= '1;
            ext_q      <= '0;
            cut_q      <= '0;
            done_q     <= 1'b0;
            rx_tq      <= 1'b1;
            bit_start  <= 1'b0;
            sample_stb <= 1'b0;
            rx_bit     <= 1'b1;
        end else begin
            bit_start  <= 1'b0;
            sample_stb <= 1'b0;
            if (tq_tick) begin
                rx_tq <= rx_s;
                case (seg_q)
                    SEG_SYNC: begin
                        seg_q <= SEG_PH1;
                        cnt_q <= '0;
                        if (fall) done_q <= 1'b1;
                    end
                    SEG_PH1: begin
                        ext_q <= ext_now;
                        if (fall) done_q <= 1'b1;
                        if (ph1_end) begin
                            seg_q      <= SEG_PH2;
                            cnt_q      <= '0;
                            sample_stb <= 1'b1;
                            rx_bit     <= rx_s;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    SEG_PH2: begin
                        cut_q <= cut_now;
                        if (fall) done_q <= 1'b1;
                        if (ph2_end) begin
                            seg_q     <= SEG_SYNC;
                            cnt_q     <= '0;
                            ext_q     <= '0;
                            cut_q     <= '0;
                            done_q    <= 1'b0;
                            bit_start <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    default: seg_q <= SEG_SYNC;
                endcase
            end
        end
    end

    assert_seg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tq_tick |=> $stable(seg_q));

    assert_sample_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        bit_start |=> !bit_start);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(bit_start && sample_stb));

    assert_ext_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        ext_q <= jump_len);

    assert_cut_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        (cut_q <= jump_len) && (ARITH_W'(cut_q) < ph2_len));

    // the single-resync flag is released only when a new bit begins
    assert_one_resync_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(done_q) |-> bit_start);

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             can_rx,
    input  logic [CFG_W-1:0] timing_cfg,
    output logic             bit_start,
    output logic             sample_stb,
    output logic             rx_bit
);
    bt_cfg_t cfg_q;
    logic    tq_tick;
    logic    rx_s;

    // capture window is the reset period only
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= bt_cfg_t'(timing_cfg);
    end

    can_tq_div u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (cfg_q.div),
        .tq_tick (tq_tick)
    );

    can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (can_rx),
        .rx_s  (rx_s)
    );

    can_bt_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .tq_tick    (tq_tick),
        .rx_s       (rx_s),
        .bit_start  (bit_start),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit)
    );

    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_q));

endmodule

// File: tb/tb_can_bit_timing.sv
`timescale 1ns/1ps
module tb_can_bit_timing;

    logic        clk = 1'b0;
    logic        rst;
    logic        can_rx;
    logic [14:0] timing_cfg;
    logic        bit_start, sample_stb, rx_bit;

    always #2 clk = ~clk;

    can_bit_timing dut (
        .clk        (clk),
        .rst        (rst),
        .can_rx     (can_rx),
        .timing_cfg (timing_cfg),
        .bit_start  (bit_start),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit)
    );

    typedef struct {
        int    len_q;
        int    samp_q;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   psc_b  = 3;

    function automatic logic [14:0] mk_cfg(int d, int a, int b, int j);
        return {2'(j), 3'(b), 4'(a), 6'(d)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // monitor: measures pulse spacing and scores against the queue
    int   start_cyc = 0;
    bit   have_start = 0;
    int   samp_off = -1;
    logic samp_val = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            have_start = 0;
            samp_off   = -1;
        end else begin
            if (sample_stb) begin
                samp_off = cyc - start_cyc;
                samp_val = rx_bit;
            end
            if (bit_start) begin
                if (have_start && sb.size() > 0) begin
                    exp_t it;
                    it = sb.pop_front();
                    check((cyc - start_cyc) == it.len_q * psc_b, it.tag, "bit length",
                          cyc - start_cyc, it.len_q * psc_b);
                    check(samp_off == it.samp_q * psc_b, it.tag, "sample offset",
                          samp_off, it.samp_q * psc_b);
                    check(samp_val === it.val, it.tag, "sampled value",
                          int'(samp_val), int'(it.val));
                end
                start_cyc  = cyc;
                have_start = 1;
                samp_off   = -1;
            end
        end
    end

    // offset from bit start at which to drive so the tick m sees the change
    function automatic int mt(int m);
        return m * psc_b - 3;
    endfunction

    task automatic run_bit(input logic lvl,
                           input int ea, input logic va,
                           input int eb, input logic vb,
                           input int ec, input logic vc,
                           input int lq, input int sq, input logic ev,
                           input string tag);
        exp_t it;
        int   last;
        do @(negedge clk); while (bit_start !== 1'b1);
        #1;
        it.len_q  = lq;
        it.samp_q = sq;
        it.val    = ev;
        it.tag    = tag;
        sb.push_back(it);
        can_rx = lvl;
        last = ea;
        if (eb > last) last = eb;
        if (ec > last) last = ec;
        for (int t = 0; t <= last; t++) begin
            if (t > 0) begin
                @(negedge clk);
                #1;
            end
            if (t == ea) can_rx = va;
            if (t == eb) can_rx = vb;
            if (t == ec) can_rx = vc;
        end
    endtask

    task automatic drain(input string tag);
        do @(negedge clk); while (bit_start !== 1'b1);
        #1;
        check(sb.size() == 0, tag, "unscored bits", sb.size(), 0);
    endtask

    task automatic do_reset(input logic [14:0] cfg, input int psc, input string tag);
        int n;
        rst        = 1'b1;
        can_rx     = 1'b1;
        timing_cfg = cfg;
        psc_b      = psc;
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        check(bit_start === 1'b0, tag, "bit_start after reset", int'(bit_start), 0);
        check(sample_stb === 1'b0, tag, "sample_stb after reset", int'(sample_stb), 0);
        check(rx_bit === 1'b1, tag, "rx_bit after reset", int'(rx_bit), 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (bit_start !== 1'b1 && n < 200);
        check(n == psc, tag, "cycles to first bit_start", n, psc);
    endtask

    initial begin
        rst        = 1'b1;
        can_rx     = 1'b1;
        timing_cfg = '0;

        // config A: PSC 3, T1 6, T2 4, SJW 2 -> 11 quanta, sample at 7
        do_reset(mk_cfg(1, 5, 3, 1), 3, "R5");
        // R1: change the fields outside reset; timing must not move
        timing_cfg = mk_cfg(63, 15, 7, 3);

        run_bit(1, -1, 1, -1, 1, -1, 1, 11, 7, 1, "R1_R3");
        run_bit(0, -1, 0, -1, 0, -1, 0, 11, 7, 0, "R6");
        run_bit(1, -1, 1, -1, 1, -1, 1, 11, 7, 1, "R9");
        run_bit(1, mt(2), 0, -1, 0, -1, 0, 12, 8, 0, "R7");
        run_bit(1, -1, 1, -1, 1, -1, 1, 11, 7, 1, "R9");
        run_bit(1, mt(6), 0, -1, 0, -1, 0, 13, 9, 0, "R7");
        run_bit(1, mt(8), 0, -1, 0, -1, 0,  9, 7, 1, "R8");
        run_bit(0, -1, 0, -1, 0, -1, 0, 11, 7, 0, "R8");
        run_bit(1, -1, 1, -1, 1, -1, 1, 11, 7, 1, "R4");
        run_bit(1, mt(10), 0, -1, 0, -1, 0, 10, 7, 1, "R8");
        run_bit(0, -1, 0, -1, 0, -1, 0, 11, 7, 0, "R4");
        // R10: second falling edge in segment 2 must be ignored
        run_bit(1, mt(2), 0, mt(9), 1, mt(10), 0, 12, 8, 0, "R10");
        run_bit(1, -1, 1, -1, 1, -1, 1, 11, 7, 1, "R9");
        // edge on the tick that would end phase 1
        run_bit(1, mt(7), 0, -1, 0, -1, 0, 13, 9, 0, "R7");
        // edge in the last quantum of phase 2: no correction
        run_bit(1, mt(11), 0, -1, 0, -1, 0, 11, 7, 1, "R8");
        run_bit(0, -1, 0, -1, 0, -1, 0, 11, 7, 0, "R8");
        drain("R3");

        // config B: smallest values, PSC 2, 3 quanta, sample at 2
        do_reset(mk_cfg(0, 0, 0, 0), 2, "R5");
        run_bit(1, -1, 1, -1, 1, -1, 1, 3, 2, 1, "R2");
        run_bit(1, -1, 1, -1, 1, -1, 1, 3, 2, 1, "R3");
        run_bit(1, -1, 1, -1, 1, -1, 1, 3, 2, 1, "R2");
        drain("R2");

        // config C: largest values, PSC 65, T1 16, T2 8, SJW 4
        do_reset(mk_cfg(63, 15, 7, 3), 65, "R5");
        run_bit(1, -1, 1, -1, 1, -1, 1, 25, 17, 1, "R2");
        run_bit(1, mt(11), 0, -1, 0, -1, 0, 29, 21, 0, "R7");
        run_bit(1, -1, 1, -1, 1, -1, 1, 25, 17, 1, "R3");
        drain("R3");

        finish_run();
    end

endmodule